// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating and Break

This block serialises characters for one asynchronous serial line. A character written by the processor first lands in a one-entry holding register. The engine copies it into a shift register at a bit-time boundary. It then sends a start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and one or two stop bits. Because of the holding register, software can queue the next character while the current one is still on the wire.

Single-cycle command pulses control the block:
- enable and disable the transmitter;
- reset the transmitter;
- start and stop a break.

Disabling lets the frame on the wire finish and keeps a queued character for later. A reset command cuts the line back to mark at once and throws the queued character away. When clear-to-send gating is selected, a character may only begin while the active-low `cts_n` input is low. A frame already under way always completes. A break holds the line low for as long as it is requested, and `cts_n` does not affect it. All inputs are synchronous to `clk`. Bit time comes from an external one-cycle strobe `bit_tick`. The frame configuration must stay constant while a frame is in flight.

The engine has six states, which are the only states the engine uses:

| State | What the line carries |
|---|---|
| IDLE | mark |
| START | the start bit |
| DATA | the data bits |
| PARITY | the parity bit |
| STOP | the stop bit or bits |
| BREAK | a continuous low |

Every transition except the reset transition happens on a `bit_tick` cycle:
- **launch**: IDLE, or STOP on its last stop bit, goes to START when a character is held, the block is enabled and clear-to-send permits.
- **break entry**: the same two points go to BREAK when a break is requested. Break entry wins over launch.
- **settle**: the same two points go to IDLE otherwise.
- **first bit**: START goes to DATA.
- **data advance**: DATA stays in DATA until the last data bit.
- **data end**: DATA then goes to PARITY, or to STOP when parity is off.
- **parity end**: PARITY goes to STOP.
- **second stop**: STOP stays in STOP for the second stop bit.
- **break exit**: BREAK goes to IDLE once the break request is withdrawn.
- **reset**: from any state, the engine goes to IDLE in the very next cycle.

Top module: `uart_tx_flow`

## Requirements
- R1: After `rst_n` is released: `txd`=1, `tx_ready`=0, `tx_empty`=1 and `irq`=0. The transmitter is disabled.
- R2: A frame has the following fields:
  - Start bit: 0.
  - Data: 5+`cfg_len` bits (`cfg_len` 0..3 selects 5..8), least significant bit first. Only the low bits of the written byte are sent.
  - Parity: `cfg_par` 1 adds an even-parity bit, 2 adds an odd-parity bit, and 0 or 3 adds none.
  - Stop: one 1-bit, or two when `cfg_two_stop`=1.
- R3: `txd` changes only in the cycle after a `bit_tick` cycle or after a reset command. Each bit therefore lasts whole bit periods.
- R4: `tx_ready` is high when the block is enabled and the holding register is empty. It drops in the cycle after an accepted write. It rises again in the cycle after the character moves to the shift register. `irq` equals `tx_ready` when `cfg_irq_en`=1 and is 0 otherwise.
- R5: A write while the block is disabled is ignored. Enabling afterwards shows `tx_ready`=1 and `tx_empty`=1, and no frame is sent.
- R6: A character that is held when the last stop bit ends starts its start bit in the very next bit period, with no idle bit between.
- R7: `tx_empty` is 1 exactly when the engine is in IDLE and no character is held. The line is then at mark. A write clears `tx_empty` in the next cycle.
- R8: A disable command lets the current frame finish. The held character is neither sent nor lost: `tx_empty` stays 0 until an enable command, after which that character is sent.
- R9: A reset command forces `txd`=1, `tx_ready`=0 and `tx_empty`=1 in the next cycle, and discards any held character. The block stays disabled until an enable command.
- R10: With `cfg_cts_en`=1, a frame starts only while `cts_n`=0. If `cts_n` rises during a frame, that frame completes and the line then stays at mark until `cts_n` falls.
- R11: A start-break command takes effect after the current frame has ended. The line is then held at 0 regardless of `cts_n`. A stop-break command returns the line to 1 at the next bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle bit-time strobe |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| cmd_enable | input | 1 | Enable-transmitter command pulse |
| cmd_disable | input | 1 | Disable-transmitter command pulse |
| cmd_reset | input | 1 | Transmitter reset command pulse |
| cmd_break_on | input | 1 | Start-break command pulse |
| cmd_break_off | input | 1 | Stop-break command pulse |
| cfg_len | input | 2 | Data length select, 5+value bits |
| cfg_par | input | 2 | Parity: 0/3 none, 1 even, 2 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_cts_en | input | 1 | 1 enables clear-to-send gating |
| cfg_irq_en | input | 1 | 1 routes ready to `irq` |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial data out, idle high |
| tx_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Nothing held and engine idle |
| irq | output | 1 | Interrupt request from ready |

## Verification
The hardest situations to reach are those where a command or a `cts_n` edge lands while a frame is mid-flight and a second character already sits in the holding register. The bench reaches them deterministically. It writes the first character, waits for the holding register to free up and writes the second. It then watches `txd` fall for the start bit and fires the disable, reset, break or `cts_n` change a few bit periods later. A bench-side serial decoder then shows which frames left the block intact, how many idle bits separated them, and whether anything at all appeared afterwards.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } tx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE3 = 2'd3
    } par_mode_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LEN_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 abort,
    input  logic                 start_ok,
    input  logic                 brk_req,
    input  logic                 hold_valid,
    input  logic [DATA_W-1:0]    hold_data,
    input  logic [LEN_SEL_W-1:0] cfg_len,
    input  logic [1:0]           cfg_par,
    input  logic                 cfg_two_stop,
    output logic                 take,
    output logic                 txd,
    output logic                 idle
);

    localparam int CNT_W   = $clog2(DATA_W);
    localparam int MIN_LEN = DATA_W - (1 << LEN_SEL_W) + 1;

    tx_state_t         state_q, state_d;
    logic [DATA_W-1:0] sh_q, sh_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              stop_q, stop_d;
    logic              par_q, par_d;
    logic              txd_q, txd_d;
    logic              load_now;

    logic [CNT_W-1:0]  last_idx;
    logic [DATA_W-1:0] mask;
    logic              par_on, par_calc, frame_end, boundary;

    // frame geometry and the decision point shared by IDLE and the last stop bit
    always_comb begin
        last_idx = CNT_W'(MIN_LEN - 1) + CNT_W'(cfg_len);
        for (int k = 0; k < DATA_W; k++) begin
            mask[k] = (CNT_W'(k) <= last_idx);
        end
        par_on    = (cfg_par == PAR_EVEN) || (cfg_par == PAR_ODD);
        par_calc  = (^(hold_data & mask)) ^ (cfg_par == PAR_ODD);
        frame_end = (state_q == ST_STOP) && (!cfg_two_stop || stop_q);
        boundary  = tick && ((state_q == ST_IDLE) || frame_end);
    end

    // next-state process
    always_comb begin
        state_d  = state_q;
        sh_d     = sh_q;
        cnt_d    = cnt_q;
        stop_d   = stop_q;
        par_d    = par_q;
        txd_d    = txd_q;
        load_now = 1'b0;
        if (abort) begin
            state_d = ST_IDLE;                      // reset transition
            txd_d   = 1'b1;
        end else if (boundary) begin
            if (brk_req) begin                      // break entry
                state_d = ST_BREAK;
                txd_d   = 1'b0;
            end else if (start_ok && hold_valid) begin  // launch
                state_d  = ST_START;
                txd_d    = 1'b0;
                sh_d     = hold_data & mask;
                par_d    = par_calc;
                load_now = 1'b1;
            end else begin                          // settle
                state_d = ST_IDLE;
                txd_d   = 1'b1;
            end
        end else if (tick) begin
            unique case (state_q)
                ST_START: begin                     // first bit
                    state_d = ST_DATA;
                    txd_d   = sh_q[0];
                    sh_d    = sh_q >> 1;
                    cnt_d   = '0;
                end
                ST_DATA: begin
                    if (cnt_q == last_idx) begin    // data end
                        if (par_on) begin
                            state_d = ST_PARITY;
                            txd_d   = par_q;
                        end else begin
                            state_d = ST_STOP;
                            txd_d   = 1'b1;
                            stop_d  = 1'b0;
                        end
                    end else begin                  // data advance
                        cnt_d = cnt_q + 1'b1;
                        txd_d = sh_q[0];
                        sh_d  = sh_q >> 1;
                    end
                end
                ST_PARITY: begin                    // parity end
                    state_d = ST_STOP;
                    txd_d   = 1'b1;
                    stop_d  = 1'b0;
                end
                ST_STOP: begin                      // second stop
                    stop_d = 1'b1;
                end
                ST_BREAK: begin
                    if (!brk_req) begin             // break exit
                        state_d = ST_IDLE;
                        txd_d   = 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            stop_q  <= 1'b0;
            par_q   <= 1'b0;
            txd_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            sh_q    <= sh_d;
            cnt_q   <= cnt_d;
            stop_q  <= stop_d;
            par_q   <= par_d;
            txd_q   <= txd_d;
        end
    end

    // output process
    always_comb begin
        take = load_now;
        txd  = txd_q;
        idle = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              cmd_reset,
    input  logic              cmd_break_on,
    input  logic              cmd_break_off,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_par,
    input  logic              cfg_two_stop,
    input  logic              cfg_cts_en,
    input  logic              cfg_irq_en,
    input  logic              cts_n,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              irq
);

    logic              tx_en;
    logic              brk_req;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    logic              wr_accept;
    logic              take;
    logic              start_ok;
    logic              eng_idle;

    // command handling: reset outranks disable, disable outranks enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en   <= 1'b0;
            brk_req <= 1'b0;
        end else if (cmd_reset) begin
            tx_en   <= 1'b0;
            brk_req <= 1'b0;
        end else begin
            if (cmd_disable)       tx_en <= 1'b0;
            else if (cmd_enable)   tx_en <= 1'b1;
            if (cmd_break_off)     brk_req <= 1'b0;
            else if (cmd_break_on) brk_req <= 1'b1;
        end
    end

    always_comb begin
        wr_accept = wr_en && tx_en && !hold_valid;
        start_ok  = tx_en && (!cfg_cts_en || !cts_n);
        tx_ready  = tx_en && !hold_valid;
        tx_empty  = eng_idle && !hold_valid;
        irq       = cfg_irq_en && tx_ready;
    end

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cmd_reset),
        .load      (wr_accept),
        .load_data (wr_data),
        .take      (take),
        .valid     (hold_valid),
        .data      (hold_data)
    );

    uart_tx_engine #(.DATA_W(DATA_W), .LEN_SEL_W(2)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (bit_tick),
        .abort        (cmd_reset),
        .start_ok     (start_ok),
        .brk_req      (brk_req),
        .hold_valid   (hold_valid),
        .hold_data    (hold_data),
        .cfg_len      (cfg_len),
        .cfg_par      (cfg_par),
        .cfg_two_stop (cfg_two_stop),
        .take         (take),
        .txd          (txd),
        .idle         (eng_idle)
    );

endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic cmd_reset,
    input logic wr_en,
    input logic cfg_cts_en,
    input logic cts_n,
    input logic brk_req,
    input logic eng_idle,
    input logic txd,
    input logic tx_ready,
    input logic tx_empty
);

    // R3: the line only moves on a bit strobe or a reset command
    assert_txd_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !cmd_reset) |=> $stable(txd));

    // R4: an accepted write removes ready in the next cycle
    assert_ready_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && wr_en) |=> !tx_ready);

    // R7: empty means the line is at mark
    assert_empty_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);

    // R9: reset command returns to mark, not ready, empty
    assert_reset_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (txd && !tx_ready && tx_empty));

    // R10: an idle engine blocked by clear-to-send keeps mark
    assert_cts_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_idle && cfg_cts_en && cts_n && !brk_req && !cmd_reset) |=> txd);

endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .cmd_reset  (cmd_reset),
    .wr_en      (wr_en),
    .cfg_cts_en (cfg_cts_en),
    .cts_n      (cts_n),
    .brk_req    (brk_req),
    .eng_idle   (eng_idle),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .tx_empty   (tx_empty)
);

// File: tb/uart_tx_flow_tb.sv
module uart_tx_flow_tb;

    localparam int TICK_DIV = 4;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_reset = 1'b0;
    logic       cmd_break_on = 1'b0, cmd_break_off = 1'b0;
    logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0;
    logic       cfg_two_stop = 1'b0, cfg_cts_en = 1'b0, cfg_irq_en = 1'b1;
    logic       cts_n = 1'b0;
    logic       txd, tx_ready, tx_empty, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_cnt = 0;
    bit line[$];

    uart_tx_flow #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
        .cmd_break_on(cmd_break_on), .cmd_break_off(cmd_break_off),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop),
        .cfg_cts_en(cfg_cts_en), .cfg_irq_en(cfg_irq_en), .cts_n(cts_n),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .irq(irq)
    );

    always #5 clk = ~clk;

    // bit strobe plus a line sampler: one sample per bit period, taken before the strobe edge
    always @(negedge clk) begin
        if (tick_cnt == TICK_DIV - 1) begin
            tick_cnt = 0;
            line.push_back(txd);
            bit_tick = 1'b1;
        end else begin
            tick_cnt = tick_cnt + 1;
            bit_tick = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > WD_LIMIT) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!cond) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int flen();
        return 5 + int'(cfg_len);
    endfunction

    function automatic bit par_on();
        return (cfg_par == 2'd1) || (cfg_par == 2'd2);
    endfunction

    function automatic bit exp_par(input logic [7:0] d);
        return (^d) ^ (cfg_par == 2'd2);
    endfunction

    function automatic logic [7:0] low_bits(input logic [7:0] d);
        return d & 8'((1 << flen()) - 1);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bits(input int n);
        cyc(n * TICK_DIV);
    endtask

    task automatic pulse(input int sel);
        case (sel)
            0: cmd_enable    = 1'b1;
            1: cmd_disable   = 1'b1;
            2: cmd_reset     = 1'b1;
            3: cmd_break_on  = 1'b1;
            default: cmd_break_off = 1'b1;
        endcase
        @(negedge clk);
        {cmd_enable, cmd_disable, cmd_reset, cmd_break_on, cmd_break_off} = '0;
    endtask

    task automatic write_char(input logic [7:0] d);
        int t = 0;
        while (!tx_ready && t < 5000) begin
            @(negedge clk);
            t++;
        end
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        int t = 0;
        while (!tx_empty && t < 20000) begin
            @(negedge clk);
            t++;
        end
        wait_bits(1);
    endtask

    task automatic wait_txd_low();
        int t = 0;
        while (txd && t < 20000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // software receiver over the sampled line
    task automatic decode_one(output bit ok, output logic [7:0] d, output int gap);
        int need;
        ok = 1'b0;
        d = '0;
        gap = 0;
        while (line.size() > 0 && line[0] == 1'b1) begin
            void'(line.pop_front());
            gap++;
        end
        need = 1 + flen() + (par_on() ? 1 : 0) + (cfg_two_stop ? 2 : 1);
        if (line.size() < need) return;
        ok = (line.pop_front() == 1'b0);
        for (int i = 0; i < flen(); i++) d[i] = line.pop_front();
        if (par_on()) ok &= (line.pop_front() == exp_par(d));
        ok &= (line.pop_front() == 1'b1);
        if (cfg_two_stop) ok &= (line.pop_front() == 1'b1);
    endtask

    task automatic expect_frame(input logic [7:0] exp, input string req, input int exp_gap);
        bit ok;
        logic [7:0] d;
        int gap;
        decode_one(ok, d, gap);
        check(ok && d == exp, req, ok ? int'(d) : -1, int'(exp));
        if (exp_gap >= 0) check(gap == exp_gap, "R6", gap, exp_gap);
    endtask

    task automatic expect_quiet(input string req);
        int z = 0;
        foreach (line[i]) if (!line[i]) z++;
        check(z == 0, req, z, 0);
        line.delete();
    endtask

    task automatic expect_all_low(input string req);
        int o = 0;
        foreach (line[i]) if (line[i]) o++;
        check(o == 0, req, o, 0);
        line.delete();
    endtask

    initial begin
        logic [7:0] q[$];
        int wait_ready;
        void'($urandom(32'd20240611));

        // R1 reset state
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(tx_ready == 1'b0, "R1 ready", tx_ready, 0);
        check(tx_empty == 1'b1, "R1 empty", tx_empty, 1);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R5 write while disabled is dropped
        wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        pulse(0);
        check(tx_ready == 1'b1, "R5 ready", tx_ready, 1);
        check(tx_empty == 1'b1, "R5 empty", tx_empty, 1);
        check(irq == 1'b1, "R4 irq on", irq, 1);
        cfg_irq_en = 1'b0;
        @(negedge clk);
        check(irq == 1'b0, "R4 irq masked", irq, 0);
        cfg_irq_en = 1'b1;
        line.delete();
        wait_bits(15);
        expect_quiet("R5 no frame");

        // R4 ready handshake, R2 basic frame 8N1
        write_char(8'hA7);
        check(tx_ready == 1'b0, "R4 ready drops", tx_ready, 0);
        check(tx_empty == 1'b0, "R7 empty clears", tx_empty, 0);
        wait_ready = 0;
        while (!tx_ready && wait_ready < 20) begin
            @(negedge clk);
            wait_ready++;
        end
        check(wait_ready <= TICK_DIV + 1, "R4 ready returns", wait_ready, TICK_DIV + 1);
        wait_empty();
        expect_frame(8'hA7, "R2 8N1", -1);

        // R2 R6 R7 random frame formats, back-to-back characters
        for (int cfg = 0; cfg < 8; cfg++) begin
            cfg_len = 2'($urandom % 4);
            cfg_par = 2'($urandom % 4);
            cfg_two_stop = 1'($urandom % 2);
            line.delete();
            q.delete();
            check(tx_empty == 1'b1 && txd == 1'b1, "R7 idle empty", int'(tx_empty), 1);
            for (int n = 0; n < 6; n++) begin
                logic [7:0] d = 8'($urandom);
                write_char(d);
                q.push_back(low_bits(d));
            end
            wait_empty();
            for (int n = 0; n < 6; n++) expect_frame(q[n], "R2 random", n == 0 ? -1 : 0);
        end

        cfg_len = 2'd3; cfg_par = 2'd1; cfg_two_stop = 1'b0;
        line.delete();

        // R8 disable mid-frame keeps the held character
        write_char(8'h3C);
        write_char(8'hC5);
        pulse(1);
        wait_bits(20);
        check(tx_ready == 1'b0, "R8 ready off", tx_ready, 0);
        check(tx_empty == 1'b0, "R8 held kept", tx_empty, 1'b0);
        expect_frame(8'h3C, "R8 first done", -1);
        expect_quiet("R8 held not sent");
        pulse(0);
        wait_empty();
        expect_frame(8'hC5, "R8 sent after enable", -1);

        // R9 reset command mid-frame
        cfg_par = 2'd0;
        line.delete();
        write_char(8'h00);
        write_char(8'h81);
        wait_bits(3);
        pulse(2);
        check(txd == 1'b1, "R9 mark", txd, 1);
        check(tx_ready == 1'b0, "R9 ready", tx_ready, 0);
        check(tx_empty == 1'b1, "R9 discard", tx_empty, 1);
        line.delete();
        wait_bits(15);
        expect_quiet("R9 stays disabled");
        pulse(0);
        check(tx_ready == 1'b1 && tx_empty == 1'b1, "R9 nothing held", int'(tx_empty), 1);
        wait_bits(15);
        expect_quiet("R9 no held frame");

        // R10 clear-to-send gating
        cfg_cts_en = 1'b1;
        cts_n = 1'b1;
        line.delete();
        write_char(8'h96);
        wait_bits(15);
        check(tx_ready == 1'b0, "R10 held", tx_ready, 0);
        expect_quiet("R10 blocked");
        cts_n = 1'b0;
        wait_empty();
        expect_frame(8'h96, "R10 released", -1);
        write_char(8'h11);
        wait_txd_low();
        write_char(8'hEE);
        cts_n = 1'b1;
        wait_bits(20);
        expect_frame(8'h11, "R10 mid-frame completes", -1);
        expect_quiet("R10 mark after");
        check(tx_empty == 1'b0, "R10 second waits", tx_empty, 0);
        cts_n = 1'b0;
        wait_empty();
        expect_frame(8'hEE, "R10 second sent", -1);

        // R11 break after current frame, ignoring clear-to-send
        write_char(8'h6B);
        wait_txd_low();
        pulse(3);
        cts_n = 1'b1;
        wait_bits(20);
        expect_frame(8'h6B, "R11 frame intact", -1);
        expect_all_low("R11 line low");
        check(txd == 1'b0, "R11 txd low", txd, 0);
        pulse(4);
        wait_bits(2);
        check(txd == 1'b1, "R11 break off", txd, 1);
        cts_n = 1'b0;
        cfg_cts_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule